// File: doc/BRIEF.md
# Write Guard and Status Register Controller

This block keeps the status register of a small serial nonvolatile memory and rules on every request to change the memory. It sits between the command decoder of the serial front end and the write-cycle timer. For each decoded command strobe it decides, in the same cycle, whether the request may start a programming cycle. It also tracks the arming latch, the busy flag and the two-bit guard code that marks part of the array as read-only.

The arming latch must be set by an explicit enable command before anything can be changed. The latch drops again after any modifying command has been evaluated. A granted command raises the busy flag, and the flag stays up until the timer reports completion. While the flag is up, modifying commands are dropped without touching any state. The guard code fences off nothing, the top quarter, the top half or the whole array. The status byte is always readable on `status_q`.

Top module: `wp_status_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it is released, `status_q` reads 0x00 (guard code 00 at its default) and `wr_grant` and `cmd_ignored` are low until a command arrives. Asserting `rst_n` clears the status at once, without waiting for a clock.
- R2: When idle, an enable strobe (`cmd_wren`) sets status bit 1 (the arming latch) at the next clock edge. A disable strobe (`cmd_wrdi`) clears it at the next clock edge.
- R3: With the latch clear, every modifying strobe (`cmd_write`, `cmd_wrsr`, `cmd_setall`, `cmd_eraseall`) gets `wr_grant`=0 and `cmd_ignored`=1 in the same cycle, and it changes neither the guard code nor the busy flag.
- R4: An array write (`cmd_write`) with the latch set and the busy flag clear is granted unless `tgt_addr` falls in the guarded range. Guard code 00 guards nothing, 01 guards addresses 0xC0 to 0xFF, 10 guards 0x80 to 0xFF, and 11 guards every address. A refused write raises `cmd_ignored`.
- R5: A whole-array fill or erase (`cmd_setall`, `cmd_eraseall`) is granted only when the latch is set, the busy flag is clear and the guard code is 00. Otherwise it is ignored.
- R6: Any modifying strobe that arrives while the busy flag is clear clears the latch at the next edge, whether or not it was granted.
- R7: A grant sets status bit 0 (busy) at the next edge. Busy stays set until a cycle with `wr_done` high, and clears at the edge that ends that cycle.
- R8: While busy, every modifying strobe is ignored (`cmd_ignored`=1, no grant). The latch, the guard code and the busy flag all keep their values.
- R9: Enable and disable strobes take effect while busy, in the same way as when idle.
- R10: A granted status write loads `guard_in` into status bits 3:2 at the next edge. No other event changes those bits.
- R11: `wr_done` has no effect while busy is clear. A modifying strobe in the same cycle as `wr_done` still sees the busy flag and is ignored, while the busy flag clears.
- R12: Status bits 7:4 always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous assert |
| cmd_wren | input | 1 | Enable strobe: arm the latch |
| cmd_wrdi | input | 1 | Disable strobe: disarm the latch |
| cmd_write | input | 1 | Array write request |
| cmd_wrsr | input | 1 | Status write request |
| cmd_setall | input | 1 | Whole-array fill request |
| cmd_eraseall | input | 1 | Whole-array erase request |
| tgt_addr | input | 8 | Target byte address of an array write |
| guard_in | input | 2 | New guard code carried by a status write |
| wr_done | input | 1 | End of programming cycle from the timer |
| wr_grant | output | 1 | Request may start a programming cycle (same cycle) |
| cmd_ignored | output | 1 | Modifying request was refused (same cycle) |
| status_q | output | 8 | Status byte: bit 0 busy, bit 1 latch, bits 3:2 guard code |

## Verification
The bench probes the address just below and just at each guard boundary (0xBF/0xC0 and 0x7F/0x80). A comparator off by one would grant a write into the fenced region or refuse a legal one. It sends refused writes with the latch set and checks that the latch still drops, which catches a design that clears the latch only on a grant and leaves the part armed. It sends modifying strobes during the busy window, including one in the same cycle as `wr_done`, which catches a design that re-grants early or lets a status write rewrite the guard code mid-programming. It also checks that an enable strobe still works while busy, and that the status clears immediately when reset is asserted.

// File: rtl/wp_pkg.sv
package wp_pkg;

  typedef enum logic [2:0] {
    OP_NONE     = 3'd0,
    OP_WREN     = 3'd1,
    OP_WRDI     = 3'd2,
    OP_WRITE    = 3'd3,
    OP_WRSR     = 3'd4,
    OP_SETALL   = 3'd5,
    OP_ERASEALL = 3'd6
  } op_e;

  typedef enum logic [1:0] {
    GUARD_NONE = 2'b00,
    GUARD_QTR  = 2'b01,
    GUARD_HALF = 2'b10,
    GUARD_ALL  = 2'b11
  } guard_e;

  typedef struct packed {
    guard_e guard;
    logic   wel;
    logic   wip;
  } stat_t;

  localparam int STAT_W = 8;

  function automatic logic is_modify(op_e op);
    return (op == OP_WRITE) || (op == OP_WRSR) ||
           (op == OP_SETALL) || (op == OP_ERASEALL);
  endfunction

endpackage

// File: rtl/wp_rst_sync.sv
module wp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_raw,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_raw) begin
    if (!rst_n_raw) sync_q <= '0;
    else            sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/wp_op_decode.sv
module wp_op_decode
  import wp_pkg::*;
(
  input  logic cmd_wren,
  input  logic cmd_wrdi,
  input  logic cmd_write,
  input  logic cmd_wrsr,
  input  logic cmd_setall,
  input  logic cmd_eraseall,
  output op_e  op
);
  // Strobes are one-hot by contract; modifying strobes win if several rise.
  always_comb begin
    op = OP_NONE;
    if      (cmd_eraseall) op = OP_ERASEALL;
    else if (cmd_setall)   op = OP_SETALL;
    else if (cmd_wrsr)     op = OP_WRSR;
    else if (cmd_write)    op = OP_WRITE;
    else if (cmd_wrdi)     op = OP_WRDI;
    else if (cmd_wren)     op = OP_WREN;
  end
endmodule

// File: rtl/wp_zone_check.sv
module wp_zone_check
  import wp_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  guard_e            guard,
  output logic              addr_locked,
  output logic              any_locked
);
  localparam logic [ADDR_W:0] DEPTH_W   = (ADDR_W+1)'(1) << ADDR_W;
  localparam logic [ADDR_W:0] HALF_BASE = DEPTH_W >> 1;
  localparam logic [ADDR_W:0] QTR_BASE  = DEPTH_W - (DEPTH_W >> 2);

  logic [ADDR_W:0] addr_x;
  assign addr_x = {1'b0, addr};

  always_comb begin
    unique case (guard)
      GUARD_NONE: addr_locked = 1'b0;
      GUARD_QTR:  addr_locked = (addr_x >= QTR_BASE);
      GUARD_HALF: addr_locked = (addr_x >= HALF_BASE);
      GUARD_ALL:  addr_locked = 1'b1;
      default:    addr_locked = 1'b1;
    endcase
  end

  assign any_locked = (guard != GUARD_NONE);
endmodule

// File: rtl/wp_stat_regs.sv
module wp_stat_regs
  import wp_pkg::*;
#(
  parameter logic [1:0] GUARD_RST = 2'b00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  op_e        op,
  input  logic       grant,
  input  logic       wr_done,
  input  logic [1:0] guard_in,
  output stat_t      stat_q
);
  logic   wel_en, wel_d;
  logic   wip_en, wip_d;
  logic   grd_en;
  guard_e grd_d;

  // Next-state
  always_comb begin
    wel_en = 1'b0;
    wel_d  = stat_q.wel;
    if (is_modify(op) && !stat_q.wip) begin
      wel_en = 1'b1;
      wel_d  = 1'b0;
    end else if (op == OP_WRDI) begin
      wel_en = 1'b1;
      wel_d  = 1'b0;
    end else if (op == OP_WREN) begin
      wel_en = 1'b1;
      wel_d  = 1'b1;
    end

    wip_en = 1'b0;
    wip_d  = stat_q.wip;
    if (grant) begin
      wip_en = 1'b1;
      wip_d  = 1'b1;
    end else if (wr_done && stat_q.wip) begin
      wip_en = 1'b1;
      wip_d  = 1'b0;
    end

    grd_en = grant && (op == OP_WRSR);
    grd_d  = guard_e'(guard_in);
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q.wel   <= 1'b0;
      stat_q.wip   <= 1'b0;
      stat_q.guard <= guard_e'(GUARD_RST);
    end else begin
      if (wel_en) stat_q.wel   <= wel_d;
      if (wip_en) stat_q.wip   <= wip_d;
      if (grd_en) stat_q.guard <= grd_d;
    end
  end
endmodule

// File: rtl/wp_status_ctrl.sv
module wp_status_ctrl
  import wp_pkg::*;
#(
  parameter int         ADDR_W      = 8,
  parameter int         SYNC_STAGES = 2,
  parameter logic [1:0] GUARD_RST   = 2'b00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wren,
  input  logic              cmd_wrdi,
  input  logic              cmd_write,
  input  logic              cmd_wrsr,
  input  logic              cmd_setall,
  input  logic              cmd_eraseall,
  input  logic [ADDR_W-1:0] tgt_addr,
  input  logic [1:0]        guard_in,
  input  logic              wr_done,
  output logic              wr_grant,
  output logic              cmd_ignored,
  output logic [STAT_W-1:0] status_q
);
  localparam int PAD_W = STAT_W - $bits(stat_t);

  logic  rst_n_s;
  op_e   op;
  stat_t stat;
  logic  addr_locked, any_locked;
  logic  target_ok, modify;

  wp_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n_raw(rst_n), .rst_n_sync(rst_n_s)
  );

  wp_op_decode u_dec (
    .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi), .cmd_write(cmd_write),
    .cmd_wrsr(cmd_wrsr), .cmd_setall(cmd_setall), .cmd_eraseall(cmd_eraseall),
    .op(op)
  );

  wp_zone_check #(.ADDR_W(ADDR_W)) u_zone (
    .addr(tgt_addr), .guard(stat.guard),
    .addr_locked(addr_locked), .any_locked(any_locked)
  );

  // Grant decision, same cycle as the strobe
  always_comb begin
    modify = is_modify(op);
    unique case (op)
      OP_WRITE:              target_ok = !addr_locked;
      OP_WRSR:               target_ok = 1'b1;
      OP_SETALL, OP_ERASEALL: target_ok = !any_locked;
      default:               target_ok = 1'b0;
    endcase
    wr_grant    = modify && !stat.wip && stat.wel && target_ok;
    cmd_ignored = modify && !wr_grant;
  end

  wp_stat_regs #(.GUARD_RST(GUARD_RST)) u_regs (
    .clk(clk), .rst_n(rst_n_s), .op(op), .grant(wr_grant),
    .wr_done(wr_done), .guard_in(guard_in), .stat_q(stat)
  );

  assign status_q = {{PAD_W{1'b0}}, stat};
endmodule

// File: rtl/wp_status_ctrl_chk.sv
module wp_status_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_wren,
  input logic       cmd_wrdi,
  input logic       cmd_write,
  input logic       cmd_wrsr,
  input logic       cmd_setall,
  input logic       cmd_eraseall,
  input logic       wr_done,
  input logic       wr_grant,
  input logic       cmd_ignored,
  input logic [7:0] status_q
);
  logic mod_any;
  assign mod_any = cmd_write | cmd_wrsr | cmd_setall | cmd_eraseall;

  AST_GRANT_NEEDS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    wr_grant |-> status_q[1]); // R3
  AST_NO_GRANT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    status_q[0] |-> !wr_grant); // R8
  AST_FULL_GUARD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_write && status_q[3:2] == 2'b11) |-> !wr_grant); // R4
  AST_BULK_NEEDS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_setall || cmd_eraseall) && status_q[3:2] != 2'b00) |-> !wr_grant); // R5
  AST_LATCH_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_any && !status_q[0]) |=> !status_q[1]); // R6
  AST_BUSY_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_grant |=> status_q[0]); // R7
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q[0] && !wr_done) |=> status_q[0]); // R7
  AST_ENABLE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wren && !mod_any && !cmd_wrdi) |=> status_q[1]); // R9
  AST_GUARD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_wrsr && wr_grant) |=> $stable(status_q[3:2])); // R10
  AST_IGNORE_ONLY_MODIFY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ignored |-> (mod_any && !wr_grant)); // R3
  AST_HIGH_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    status_q[7:4] == 4'h0); // R12
endmodule

bind wp_status_ctrl wp_status_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi), .cmd_write(cmd_write),
  .cmd_wrsr(cmd_wrsr), .cmd_setall(cmd_setall), .cmd_eraseall(cmd_eraseall),
  .wr_done(wr_done), .wr_grant(wr_grant), .cmd_ignored(cmd_ignored),
  .status_q(status_q)
);

// File: tb/wp_status_ctrl_bench.sv
module wp_status_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 44;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmd_wren, cmd_wrdi, cmd_write, cmd_wrsr, cmd_setall, cmd_eraseall;
  logic [7:0] tgt_addr;
  logic [1:0] guard_in;
  logic       wr_done;
  logic       wr_grant, cmd_ignored;
  logic [7:0] status_q;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wp_status_ctrl u_wp_status_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi), .cmd_write(cmd_write),
    .cmd_wrsr(cmd_wrsr), .cmd_setall(cmd_setall), .cmd_eraseall(cmd_eraseall),
    .tgt_addr(tgt_addr), .guard_in(guard_in), .wr_done(wr_done),
    .wr_grant(wr_grant), .cmd_ignored(cmd_ignored), .status_q(status_q)
  );

  // {req[4], cmd[3], addr[8], guard_in[2], done, exp_grant, exp_ignored, exp_status[8]}
  // cmd: 0 none, 1 enable, 2 disable, 3 write, 4 status write, 5 fill, 6 erase
  // status: bit0 busy, bit1 latch, bits3:2 guard code
  localparam logic [27:0] VEC [NV] = '{
    {4'd1,  3'd0, 8'h00, 2'd0, 1'b0, 1'b0, 1'b0, 8'h00}, // R1 idle
    {4'd3,  3'd3, 8'h10, 2'd0, 1'b0, 1'b0, 1'b1, 8'h00}, // R3 write unarmed
    {4'd3,  3'd4, 8'h00, 2'd3, 1'b0, 1'b0, 1'b1, 8'h00}, // R3 status write unarmed
    {4'd2,  3'd1, 8'h00, 2'd0, 1'b0, 1'b0, 1'b0, 8'h02}, // R2 arm
    {4'd2,  3'd2, 8'h00, 2'd0, 1'b0, 1'b0, 1'b0, 8'h00}, // R2 disarm
    {4'd2,  3'd1, 8'h00, 2'd0, 1'b0, 1'b0, 1'b0, 8'h02}, // R2 arm
    {4'd4,  3'd3, 8'h10, 2'd0, 1'b0, 1'b1, 1'b0, 8'h01}, // R4 open write
    {4'd7,  3'd0, 8'h00, 2'd0, 1'b0, 1'b0, 1'b0, 8'h01}, // R7 busy holds
    {4'd9,  3'd1, 8'h00, 2'd0, 1'b0, 1'b0, 1'b0, 8'h03}, // R9 arm while busy
    {4'd8,  3'd3, 8'h20, 2'd0, 1'b0, 1'b0, 1'b1, 8'h03}, // R8 write while busy
    {4'd8,  3'd4, 8'h00, 2'd3, 1'b0, 1'b0, 1'b1, 8'h03}, // R8 status write while busy
    {4'd7,  3'd0, 8'h00, 2'd0, 1'b1, 1'b0, 1'b0, 8'h02}, // R7 done
    {4'd11, 3'd0, 8'h00, 2'd0, 1'b1, 1'b0, 1'b0, 8'h02}, // R11 done while idle
    {4'd10, 3'd4, 8'h00, 2'd1, 1'b0, 1'b1, 1'b0, 8'h05}, // R10 guard quarter
    {4'd7,  3'd0, 8'h00, 2'd0, 1'b1, 1'b0, 1'b0, 8'h04}, // R7
    {4'd2,  3'd1, 8'h00, 2'd0, 1'b0, 1'b0, 1'b0, 8'h06}, // R2
    {4'd4,  3'd3, 8'hC0, 2'd0, 1'b0, 1'b0, 1'b1, 8'h04}, // R4 quarter boundary refused
    {4'd2,  3'd1, 8'h00, 2'd0, 1'b0, 1'b0, 1'b0, 8'h06}, // R2
    {4'd4,  3'd3, 8'hBF, 2'd0, 1'b0, 1'b1, 1'b0, 8'h05}, // R4 just below quarter
    {4'd7,  3'd0, 8'h00, 2'd0, 1'b1, 1'b0, 1'b0, 8'h04}, // R7
    {4'd2,  3'd1, 8'h00, 2'd0, 1'b0, 1'b0, 1'b0, 8'h06}, // R2
    {4'd5,  3'd5, 8'h00, 2'd0, 1'b0, 1'b0, 1'b1, 8'h04}, // R5 fill refused under guard
    {4'd2,  3'd1, 8'h00, 2'd0, 1'b0, 1'b0, 1'b0, 8'h06}, // R2
    {4'd10, 3'd4, 8'h00, 2'd2, 1'b0, 1'b1, 1'b0, 8'h09}, // R10 guard half
    {4'd7,  3'd0, 8'h00, 2'd0, 1'b1, 1'b0, 1'b0, 8'h08}, // R7
    {4'd2,  3'd1, 8'h00, 2'd0, 1'b0, 1'b0, 1'b0, 8'h0A}, // R2
    {4'd6,  3'd3, 8'h80, 2'd0, 1'b0, 1'b0, 1'b1, 8'h08}, // R6 refused still disarms
    {4'd2,  3'd1, 8'h00, 2'd0, 1'b0, 1'b0, 1'b0, 8'h0A}, // R2
    {4'd4,  3'd3, 8'h7F, 2'd0, 1'b0, 1'b1, 1'b0, 8'h09}, // R4 just below half
    {4'd9,  3'd1, 8'h00, 2'd0, 1'b0, 1'b0, 1'b0, 8'h0B}, // R9 arm while busy
    {4'd11, 3'd4, 8'h00, 2'd0, 1'b1, 1'b0, 1'b1, 8'h0A}, // R11 status write with done
    {4'd10, 3'd4, 8'h00, 2'd3, 1'b0, 1'b1, 1'b0, 8'h0D}, // R10 guard all
    {4'd7,  3'd0, 8'h00, 2'd0, 1'b1, 1'b0, 1'b0, 8'h0C}, // R7
    {4'd2,  3'd1, 8'h00, 2'd0, 1'b0, 1'b0, 1'b0, 8'h0E}, // R2
    {4'd4,  3'd3, 8'h00, 2'd0, 1'b0, 1'b0, 1'b1, 8'h0C}, // R4 all guarded
    {4'd2,  3'd1, 8'h00, 2'd0, 1'b0, 1'b0, 1'b0, 8'h0E}, // R2
    {4'd10, 3'd4, 8'h00, 2'd0, 1'b0, 1'b1, 1'b0, 8'h01}, // R10 back to open
    {4'd7,  3'd0, 8'h00, 2'd0, 1'b1, 1'b0, 1'b0, 8'h00}, // R7
    {4'd2,  3'd1, 8'h00, 2'd0, 1'b0, 1'b0, 1'b0, 8'h02}, // R2
    {4'd5,  3'd6, 8'h00, 2'd0, 1'b0, 1'b1, 1'b0, 8'h01}, // R5 erase granted
    {4'd7,  3'd0, 8'h00, 2'd0, 1'b1, 1'b0, 1'b0, 8'h00}, // R7
    {4'd2,  3'd1, 8'h00, 2'd0, 1'b0, 1'b0, 1'b0, 8'h02}, // R2
    {4'd5,  3'd5, 8'h00, 2'd0, 1'b0, 1'b1, 1'b0, 8'h01}, // R5 fill granted
    {4'd12, 3'd0, 8'h00, 2'd0, 1'b1, 1'b0, 1'b0, 8'h00}  // R12 high bits zero
  };

  task automatic check(input int req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] cmd, input logic [7:0] a,
                       input logic [1:0] g, input logic d);
    cmd_wren     = (cmd == 3'd1);
    cmd_wrdi     = (cmd == 3'd2);
    cmd_write    = (cmd == 3'd3);
    cmd_wrsr     = (cmd == 3'd4);
    cmd_setall   = (cmd == 3'd5);
    cmd_eraseall = (cmd == 3'd6);
    tgt_addr     = a;
    guard_in     = g;
    wr_done      = d;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0;
    drive(3'd0, 8'h00, 2'd0, 1'b0);
    repeat (3) @(negedge clk);
    check(1, "status in reset", status_q, 8'h00);             // R1
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(1, "status after release", status_q, 8'h00);       // R1
    check(1, "grant after release", {7'd0, wr_grant}, 8'h00); // R1

    for (int i = 0; i < NV; i++) begin
      automatic logic [27:0] v = VEC[i];
      automatic int req = int'(v[27:24]);
      drive(v[23:21], v[20:13], v[12:11], v[10]);
      #1;
      check(req, "grant", {7'd0, wr_grant}, {7'd0, v[9]});
      check(req, "ignored", {7'd0, cmd_ignored}, {7'd0, v[8]});
      @(negedge clk);
      check(req, "status", status_q, v[7:0]);
    end

    // Asynchronous reset assertion mid-run: R1
    drive(3'd1, 8'h00, 2'd0, 1'b0);
    @(negedge clk);
    drive(3'd0, 8'h00, 2'd0, 1'b0);
    check(2, "armed before reset", status_q, 8'h02);          // R2
    #2 rst_n = 1'b0;
    #1;
    check(1, "status right after reset edge", status_q, 8'h00); // R1
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // Unarmed erase after reset is refused: R3
    drive(3'd6, 8'h00, 2'd0, 1'b0);
    #1;
    check(3, "erase after reset ignored", {7'd0, cmd_ignored}, 8'h01);
    @(negedge clk);
    drive(3'd0, 8'h00, 2'd0, 1'b0);
    check(3, "status after refused erase", status_q, 8'h00);

    finished = 1'b1;
    finish_run();
  end
endmodule